// File: doc/BRIEF.md
# Transmit/Receive Byte Queue Pair with Interrupt Bank

This block holds the data path between a host and a serial bit engine. It has one byte queue for outgoing data and one for incoming data, each 16 entries deep by default. The host reaches both queues through a small register window: a one-cycle write strobe, a read strobe and a 3-bit address. The bit engine drains the outgoing queue and fills the incoming queue over valid/ready handshakes.

Each queue has a programmable 4-bit watermark and a flush request that runs for a fixed number of cycles. The flush request bit reads back as set while the flush runs. The block gathers queue levels, a transmit overrun and five protocol events from the engine into one 32-bit interrupt word. The word has a mask register, a masked view and write-one-to-clear latches for the event bits. A single interrupt line is the OR of the masked bits.

Top module: `dual_byte_fifo_irq`

Register window (addr): 0 control, 1 transmit data (write pushes), 2 receive data (read shows the head; a read strobe pops), 3 transmit watermark, 4 receive watermark, 5 mask, 6 raw status (read) and clear (write), 7 masked status.

## Requirements
- R1: After reset both queues are empty, the watermarks and the mask are zero, `irq` is low, the control register reads 0 and raw status reads 0x00000033.
- R2: Bytes written at addr 1 leave on `tx_data` in the order they were written. `tx_valid` is high exactly when the transmit queue holds data and no transmit flush is running.
- R3: Bytes accepted on `rx_valid`/`rx_ready` are read back in arrival order at addr 2, and each read strobe at addr 2 pops one byte. `rx_ready` is low while the receive queue is full or a receive flush is running.
- R4: A write at addr 1 while the transmit queue holds 16 bytes sets status bit 3 (transmit overrun), and the byte is discarded.
- R5: Status bit 0 means the transmit queue is empty and bit 2 means it is full. Bit 1 is set while the transmit entry count is less than or equal to the transmit watermark.
- R6: Status bit 4 means the receive queue is empty and bit 6 means it is full. Bit 5 is set while the receive entry count is greater than or equal to the receive watermark.
- R7: Writing 1 to control bit 7 (transmit) or bit 8 (receive) starts a flush. That bit reads 1 for 4 clock edges, then the queue is empty and the bit reads 0. While the flush runs, accesses to that queue from either side are ignored.
- R8: The event inputs set status bits that stay set until cleared by a 1 written at addr 6: `ev_done` sets bit 19, `ev_slv_done` bit 20, `ev_arb_lost` bit 24, `ev_bus_err` bit 25 and `ev_done_nostop` bit 28. Overrun (bit 3) is latched the same way. Writing 1 to a level bit (0-2, 4-6) has no effect.
- R9: Masked status equals raw status AND mask, and `irq` is the OR of the masked bits. Bits 31:29 of the mask, raw and masked registers always read zero.
- R10: The watermark registers keep only 4 bits, so the largest watermark is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (pops at addr 2) |
| addr | input | 3 | Register select |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data for `addr` |
| tx_data | output | 8 | Head byte of transmit queue |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the transmit byte |
| rx_data | input | 8 | Byte from engine |
| rx_valid | input | 1 | Engine offers a byte |
| rx_ready | output | 1 | Receive queue accepts a byte |
| ev_done | input | 1 | Transaction done pulse |
| ev_done_nostop | input | 1 | Transaction done without stop pulse |
| ev_slv_done | input | 1 | Target-side transaction done pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a full transmit queue never grows on a host write, and such a write raises the overrun bit;
- a flush that reaches its last cycle leaves its queue empty;
- `rx_ready` stays low while the receive queue is full;
- a latched event bit survives any cycle that does not clear it;
- `irq` tracks the masked word.

Only the bench scenarios show the following:
- byte ordering through each queue;
- the exact watermark comparisons at their edge counts;
- the four-edge flush duration seen from the control register;
- that a clear leaves the level bits untouched.

// File: rtl/dual_byte_fifo_irq.sv
module dual_byte_fifo_irq #(
  parameter int DEPTH     = 16,
  parameter int FLUSH_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic        ev_done,
  input  logic        ev_done_nostop,
  input  logic        ev_slv_done,
  input  logic        ev_arb_lost,
  input  logic        ev_bus_err,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = $clog2(FLUSH_CYC + 1);
  localparam logic [31:0] CLR_OK   = 32'h131F_007F;
  localparam logic [31:0] EVT_BITS = 32'h1318_0008;
  localparam logic [31:0] LIVE     = 32'h1FFF_FFFF;
  localparam logic [2:0] A_CTRL = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2, A_TXTH = 3'd3,
                         A_RXTH = 3'd4, A_MASK = 3'd5, A_RAW = 3'd6, A_MSK = 3'd7;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp, tx_thr, rx_thr;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [FW-1:0] tx_fl, rx_fl;
  logic [31:0]   mask_q, evt_q, evt_set, lvl, raw, masked, clr;
  logic          tx_busy, rx_busy, tx_full, rx_full;
  logic          tx_push, tx_ovr, tx_pop, rx_push, rx_pop;

  assign tx_busy  = tx_fl != '0;
  assign rx_busy  = rx_fl != '0;
  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign tx_push  = wr_en && addr == A_TXD && !tx_busy && !tx_full;
  assign tx_ovr   = wr_en && addr == A_TXD && !tx_busy && tx_full;
  assign tx_valid = tx_cnt != '0 && !tx_busy;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_data  = tx_mem[tx_rp];
  assign rx_ready = !rx_full && !rx_busy;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = rd_en && addr == A_RXD && rx_cnt != '0 && !rx_busy;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_fl == FW'(1)) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_fl == FW'(1)) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_fl <= '0; rx_fl <= '0;
    end else begin
      if (tx_busy)                                         tx_fl <= tx_fl - 1'b1;
      else if (wr_en && addr == A_CTRL && wdata[7])        tx_fl <= FW'(FLUSH_CYC);
      if (rx_busy)                                         rx_fl <= rx_fl - 1'b1;
      else if (wr_en && addr == A_CTRL && wdata[8])        rx_fl <= FW'(FLUSH_CYC);
    end
  end

  always_comb begin
    evt_set     = '0;
    evt_set[3]  = tx_ovr;
    evt_set[19] = ev_done;
    evt_set[20] = ev_slv_done;
    evt_set[24] = ev_arb_lost;
    evt_set[25] = ev_bus_err;
    evt_set[28] = ev_done_nostop;
    lvl         = '0;
    lvl[0]      = tx_cnt == '0;
    lvl[1]      = tx_cnt <= CW'(tx_thr);
    lvl[2]      = tx_full;
    lvl[4]      = rx_cnt == '0;
    lvl[5]      = rx_cnt >= CW'(rx_thr);
    lvl[6]      = rx_full;
  end

  assign clr    = (wr_en && addr == A_RAW) ? (wdata & CLR_OK) : '0;
  assign raw    = (evt_q | lvl) & LIVE;
  assign masked = raw & mask_q;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0; mask_q <= '0; tx_thr <= '0; rx_thr <= '0;
    end else begin
      evt_q <= ((evt_q & ~clr) | evt_set) & EVT_BITS;
      if (wr_en && addr == A_MASK) mask_q <= wdata & LIVE;
      if (wr_en && addr == A_TXTH) tx_thr <= wdata[AW-1:0];
      if (wr_en && addr == A_RXTH) rx_thr <= wdata[AW-1:0];
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {23'b0, rx_busy, tx_busy, 7'b0};
      A_RXD:   rdata = {24'b0, rx_mem[rx_rp]};
      A_TXTH:  rdata = 32'(tx_thr);
      A_RXTH:  rdata = 32'(rx_thr);
      A_MASK:  rdata = mask_q;
      A_RAW:   rdata = raw;
      A_MSK:   rdata = masked;
      default: rdata = '0;
    endcase
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && wr_en && addr == A_TXD && !tx_pop) |=> tx_full);
  assert_overrun_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr) |=> raw[3]);
  assert_rx_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_ready);
  assert_tx_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fl == FW'(1)) |=> (tx_cnt == '0 && !tx_busy));
  assert_rx_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fl == FW'(1)) |=> (rx_cnt == '0 && !rx_busy));
  assert_event_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[24] && !(wr_en && addr == A_RAW && wdata[24])) |=> raw[24]);
  assert_irq_follows_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw & mask_q) != 32'b0));
endmodule

// File: tb/tb_dual_byte_fifo_irq.sv
module tb_dual_byte_fifo_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] tx_data, rx_data = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic ev_done = 0, ev_done_nostop = 0, ev_slv_done = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic irq;
  int vectors = 0, miscompares = 0;
  logic finished = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_byte_fifo_irq dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic hread(logic [2:0] a, logic pop, output logic [31:0] d);
    addr = a; rd_en = pop;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic push_rx(logic [7:0] v);
    rx_data = v; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    hread(3'd6, 0, rv); chk("R1 raw after reset", rv, 32'h33);
    hread(3'd0, 0, rv); chk("R1 ctrl after reset", rv, 0);
    hread(3'd5, 0, rv); chk("R1 mask after reset", rv, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 tx_valid after reset", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_tx_order;
    logic [7:0] exp [3] = '{8'hA1, 8'hB2, 8'hC3};
    for (int i = 0; i < 3; i++) hwrite(3'd1, {24'b0, exp[i]});
    tx_ready = 1;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R2 tx_valid", {31'b0, tx_valid}, 1);
      chk("R2 tx order", {24'b0, tx_data}, {24'b0, exp[i]});
      @(negedge clk);
    end
    tx_ready = 0;
    #1 chk("R2 tx_valid after drain", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_tx_levels;
    hwrite(3'd3, 32'hFF);
    hread(3'd3, 0, rv); chk("R10 watermark width", rv, 32'hF);
    hwrite(3'd3, 2);
    for (int i = 0; i < 16; i++) begin
      hwrite(3'd1, 32'h10 + i);
      hread(3'd6, 0, rv);
      chk("R5 nearly empty", {31'b0, rv[1]}, {31'b0, (i + 1) <= 2});
      chk("R5 empty", {31'b0, rv[0]}, 0);
      chk("R5 full", {31'b0, rv[2]}, {31'b0, i == 15});
    end
    hread(3'd6, 0, rv); chk("R4 no overrun yet", {31'b0, rv[3]}, 0);
    hwrite(3'd1, 32'h5A);
    hread(3'd6, 0, rv); chk("R4 overrun set", {31'b0, rv[3]}, 1);
    tx_ready = 1;
    for (int i = 0; i < 16; i++) begin
      #1 chk("R4 drain order", {24'b0, tx_data}, 32'h10 + i);
      @(negedge clk);
    end
    tx_ready = 0;
    #1 chk("R4 dropped byte absent", {31'b0, tx_valid}, 0);
    hwrite(3'd6, 32'hF);
    hread(3'd6, 0, rv); chk("R8 clear overrun keeps levels", rv & 32'hF, 32'h3);
  endtask

  task automatic t_rx;
    hwrite(3'd4, 3);
    push_rx(8'h40); push_rx(8'h41);
    hread(3'd6, 0, rv); chk("R6 nearly full below", rv & 32'h70, 32'h00);
    push_rx(8'h42);
    hread(3'd6, 0, rv); chk("R6 nearly full at watermark", rv & 32'h70, 32'h20);
    for (int i = 3; i < 16; i++) push_rx(8'h40 + 8'(i));
    #1 chk("R3 rx_ready low when full", {31'b0, rx_ready}, 0);
    hread(3'd6, 0, rv); chk("R6 full", rv & 32'h70, 32'h60);
    push_rx(8'h99);
    for (int i = 0; i < 16; i++) begin
      hread(3'd2, 1, rv); chk("R3 rx order", rv, 32'h40 + i);
    end
    hread(3'd6, 0, rv); chk("R6 empty after reads", rv & 32'h70, 32'h10);
  endtask

  task automatic t_flush;
    hwrite(3'd1, 1); hwrite(3'd1, 2);
    hwrite(3'd0, 32'h80);
    hwrite(3'd1, 32'h77);
    #1 chk("R7 tx gated during flush", {31'b0, tx_valid}, 0);
    hread(3'd0, 0, rv); chk("R7 tx flush busy", rv, 32'h80);
    @(negedge clk);
    hread(3'd0, 0, rv); chk("R7 tx flush busy last", rv, 32'h80);
    hread(3'd0, 0, rv); chk("R7 tx flush done", rv, 0);
    hread(3'd6, 0, rv); chk("R7 tx empty after flush", rv & 32'h1, 1);
    chk("R7 no stale tx", {31'b0, tx_valid}, 0);
    push_rx(8'h55); push_rx(8'h56);
    hwrite(3'd0, 32'h100);
    #1 chk("R7 rx_ready low in flush", {31'b0, rx_ready}, 0);
    push_rx(8'h66);
    repeat (3) @(negedge clk);
    hread(3'd0, 0, rv); chk("R7 rx flush done", rv, 0);
    hread(3'd6, 0, rv); chk("R7 rx empty after flush", rv & 32'h10, 32'h10);
    chk("R7 rx_ready after flush", {31'b0, rx_ready}, 1);
  endtask

  task automatic t_events;
    ev_arb_lost = 1; @(negedge clk); ev_arb_lost = 0;
    repeat (3) @(negedge clk);
    hread(3'd6, 0, rv); chk("R8 arb lost latched", rv, 32'h0100_0013);
    chk("R9 irq masked off", {31'b0, irq}, 0);
    hwrite(3'd5, 32'hFFFF_FFFF);
    hread(3'd5, 0, rv); chk("R9 mask reserved bits", rv, 32'h1FFF_FFFF);
    hread(3'd7, 0, rv); chk("R9 masked all", rv, 32'h0100_0013);
    chk("R9 irq high", {31'b0, irq}, 1);
    hwrite(3'd5, 32'h0100_0000);
    hread(3'd7, 0, rv); chk("R9 masked one bit", rv, 32'h0100_0000);
    hwrite(3'd6, 32'h0100_0000);
    hread(3'd6, 0, rv); chk("R8 arb lost cleared", rv, 32'h13);
    chk("R9 irq low after clear", {31'b0, irq}, 0);
    ev_done = 1; ev_slv_done = 1; ev_arb_lost = 1; ev_bus_err = 1; ev_done_nostop = 1;
    @(negedge clk);
    ev_done = 0; ev_slv_done = 0; ev_arb_lost = 0; ev_bus_err = 0; ev_done_nostop = 0;
    hread(3'd6, 0, rv); chk("R8 all events", rv, 32'h1318_0013);
    hwrite(3'd6, 32'hFFFF_FFFF);
    hread(3'd6, 0, rv); chk("R8 clear all events", rv, 32'h13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_levels();
    t_rx();
    t_flush();
    t_events();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule